// File: doc/BRIEF.md
# Staged Crosspoint Circuit Configuration Controller

This block sits between a control-plane message interface and the circuit configuration registers of an N-port crosspoint switch. Configuration arrives in two separate steps. A map message carries a new peer for every port, plus a per-port change bitmap. The block checks the message for consistency, keeps it in a staging bank and acknowledges it. The live circuits do not change at this step. A later commit command copies the staged peers of the flagged ports into the active bank, all in the same clock edge. The block then acknowledges the commit and raises a one-cycle forward pulse, so the command can be repeated to peer switches on the control plane.

Every port names exactly one peer. A port whose peer is its own index is idle. Because of this, the active bank always describes a set of disjoint two-port circuits, and there are never more than N/2 of them. A map is rejected without an acknowledge when applying it would break this property. A commit that finds nothing staged has no effect. This covers a commit that repeats one already carried out.

Top module: `xpc_cfg_ctrl`

## Requirements
- R1: After reset every active entry equals its own port index (all ports idle), and ack_o and fwd_o are low.
- R2: A consistent map message (msg_kind_i = 0) is staged and answered one cycle later by ack_o = 1 with ack_commit_o = 0. The active map does not change.
- R3: A map is rejected, with no acknowledge and no change to the staged contents, when a flagged port p names a peer q ≠ p and either q is unflagged or q does not name p back. It is also rejected when a flagged port's current active peer is unflagged. Port p's entry is msg_map_i[p*PW +: PW].
- R4: A commit command (msg_kind_i = 1) that finds a staged map loads the staged entries of the flagged ports into the active map at the next edge. In that same cycle ack_o, ack_commit_o and fwd_o are all 1 for one cycle.
- R5: A commit leaves the active entry of every port whose staged bitmap bit is 0 unchanged.
- R6: A commit that finds nothing staged, including a second commit after one already applied, changes nothing and raises neither ack_o nor fwd_o.
- R7: The active map is always an involution: if port p names q, then q names p. At most N/2 circuits are therefore active.
- R8: A consistent map that arrives while another is staged replaces it completely, including its bitmap.
- R9: Inputs are ignored while msg_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid_i | input | 1 | A message is present this cycle |
| msg_kind_i | input | 1 | 0 = map message, 1 = commit command |
| msg_map_i | input | N_PORTS*PW | Peer index per port, port p at bits p*PW +: PW |
| msg_mask_i | input | N_PORTS | Change bitmap, bit p flags port p |
| ack_o | output | 1 | One-cycle acknowledge of an accepted map or applied commit |
| ack_commit_o | output | 1 | With ack_o: 1 for a commit, 0 for a map |
| fwd_o | output | 1 | One-cycle request to forward the commit to peers |
| active_map_o | output | N_PORTS*PW | Live peer index per port |

## Verification
The hardest case to reach is the rejection caused by the *active* state. Here the new map is consistent in itself, but it tears down or rewires a port whose present partner is left unflagged. Reaching it requires first committing circuits, and then sending a map that touches only one side of one of them. The bench builds this case directly. The random phase builds maps that are closed under the live pairing and then corrupts single entries. Because of that, rejections happen after varied commit histories.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  typedef enum logic {
    MSG_MAP    = 1'b0,
    MSG_COMMIT = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/xpc_map_check.sv
module xpc_map_check #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic [N*PW-1:0] map_i,
  input  logic [N-1:0]    mask_i,
  input  logic [N*PW-1:0] active_i,
  output logic [N-1:0]    bad_port_o,
  output logic            ok_o
);
  function automatic logic [PW-1:0] entry(input logic [N*PW-1:0] v, input int idx);
    return v[idx*PW +: PW];
  endfunction

  for (genvar p = 0; p < N; p++) begin : g_port
    always_comb begin : chk
      logic [PW-1:0] q;
      logic [PW-1:0] a;
      q = entry(map_i, p);
      a = entry(active_i, p);
      bad_port_o[p] = 1'b0;
      if (mask_i[p]) begin
        if (int'(q) >= N) begin
          bad_port_o[p] = 1'b1;
        end else if (int'(q) != p) begin
          if (!mask_i[q] || entry(map_i, int'(q)) != PW'(p)) bad_port_o[p] = 1'b1;
        end
        if (int'(a) >= N) begin
          bad_port_o[p] = 1'b1;
        end else if (!mask_i[a]) begin
          bad_port_o[p] = 1'b1;
        end
      end
    end
  end

  assign ok_o = ~|bad_port_o;
endmodule

// File: rtl/xpc_shadow_bank.sv
module xpc_shadow_bank #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [N*PW-1:0] map_i,
  input  logic [N-1:0]    mask_i,
  input  logic            consume_i,
  output logic [N*PW-1:0] shadow_map_o,
  output logic [N-1:0]    shadow_mask_o,
  output logic            pending_o
);
  function automatic logic [N*PW-1:0] identity_map();
    logic [N*PW-1:0] v;
    for (int i = 0; i < N; i++) v[i*PW +: PW] = PW'(i);
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_map_o  <= identity_map();
      shadow_mask_o <= '0;
      pending_o     <= 1'b0;
    end else if (load_i) begin
      shadow_map_o  <= map_i;
      shadow_mask_o <= mask_i;
      pending_o     <= 1'b1;
    end else if (consume_i) begin
      pending_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/xpc_active_bank.sv
module xpc_active_bank #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_i,
  input  logic [N*PW-1:0] shadow_map_i,
  input  logic [N-1:0]    shadow_mask_i,
  output logic [N*PW-1:0] active_map_o
);
  for (genvar p = 0; p < N; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        active_map_o[p*PW +: PW] <= PW'(p);
      else if (commit_i && shadow_mask_i[p])
        active_map_o[p*PW +: PW] <= shadow_map_i[p*PW +: PW];
    end
  end
endmodule

// File: rtl/xpc_cfg_ctrl.sv
module xpc_cfg_ctrl
  import xpc_pkg::*;
#(
  parameter int N_PORTS = 8,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid_i,
  input  logic                 msg_kind_i,
  input  logic [N_PORTS*PW-1:0] msg_map_i,
  input  logic [N_PORTS-1:0]   msg_mask_i,
  output logic                 ack_o,
  output logic                 ack_commit_o,
  output logic                 fwd_o,
  output logic [N_PORTS*PW-1:0] active_map_o
);
  logic                  is_map, is_commit;
  logic                  map_ok, map_accept, map_reject;
  logic                  commit_fire;
  logic [N_PORTS-1:0]    bad_port;
  logic [N_PORTS*PW-1:0] shadow_map;
  logic [N_PORTS-1:0]    shadow_mask;
  logic                  pending;

  assign is_map      = msg_valid_i && (msg_kind_e'(msg_kind_i) == MSG_MAP);
  assign is_commit   = msg_valid_i && (msg_kind_e'(msg_kind_i) == MSG_COMMIT);
  assign map_accept  = is_map && map_ok;
  assign map_reject  = is_map && !map_ok;
  assign commit_fire = is_commit && pending;

  xpc_map_check #(.N(N_PORTS), .PW(PW)) u_check (
    .map_i      (msg_map_i),
    .mask_i     (msg_mask_i),
    .active_i   (active_map_o),
    .bad_port_o (bad_port),
    .ok_o       (map_ok)
  );

  xpc_shadow_bank #(.N(N_PORTS), .PW(PW)) u_shadow (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (map_accept),
    .map_i         (msg_map_i),
    .mask_i        (msg_mask_i),
    .consume_i     (commit_fire),
    .shadow_map_o  (shadow_map),
    .shadow_mask_o (shadow_mask),
    .pending_o     (pending)
  );

  xpc_active_bank #(.N(N_PORTS), .PW(PW)) u_active (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit_i      (commit_fire),
    .shadow_map_i  (shadow_map),
    .shadow_mask_i (shadow_mask),
    .active_map_o  (active_map_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o        <= 1'b0;
      ack_commit_o <= 1'b0;
      fwd_o        <= 1'b0;
    end else begin
      ack_o        <= map_accept || commit_fire;
      ack_commit_o <= commit_fire;
      fwd_o        <= commit_fire;
    end
  end
endmodule

// File: rtl/xpc_cfg_ctrl_chk.sv
module xpc_cfg_ctrl_chk #(
  parameter int N_PORTS = 8,
  parameter int PW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ack_o,
  input logic                  ack_commit_o,
  input logic                  fwd_o,
  input logic [N_PORTS*PW-1:0] active_map_o,
  input logic                  map_accept,
  input logic                  map_reject,
  input logic                  commit_fire,
  input logic                  is_commit,
  input logic                  pending,
  input logic [N_PORTS-1:0]    shadow_mask
);
  logic [N_PORTS*PW-1:0] prev_active;
  logic [N_PORTS-1:0]    prev_mask;
  logic [N_PORTS-1:0]    held_ok;
  logic [N_PORTS-1:0]    pair_ok;
  logic [N_PORTS-1:0]    connected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_active <= '0;
      prev_mask   <= '0;
    end else begin
      prev_active <= active_map_o;
      prev_mask   <= shadow_mask;
    end
  end

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      logic [PW-1:0] q;
      q = active_map_o[p*PW +: PW];
      held_ok[p]   = prev_mask[p] || (active_map_o[p*PW +: PW] == prev_active[p*PW +: PW]);
      connected[p] = (int'(q) != p);
      pair_ok[p]   = (int'(q) < N_PORTS) && (active_map_o[int'(q)*PW +: PW] == PW'(p));
    end
  end

  // R2
  map_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_accept |=> ack_o && !ack_commit_o && $stable(active_map_o));

  // R3
  reject_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_reject |=> !ack_o && !fwd_o);

  // R4
  commit_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> ack_o && ack_commit_o && fwd_o);

  // R5
  unflagged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (&held_ok));

  // R6
  idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_commit && !pending) |=> !ack_o && !fwd_o && $stable(active_map_o));

  // R7
  involution_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&pair_ok) && ($countones(connected) <= N_PORTS));

  // R4
  fwd_only_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> ack_o && ack_commit_o);
endmodule

bind xpc_cfg_ctrl xpc_cfg_ctrl_chk #(.N_PORTS(N_PORTS), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack_o        (ack_o),
  .ack_commit_o (ack_commit_o),
  .fwd_o        (fwd_o),
  .active_map_o (active_map_o),
  .map_accept   (map_accept),
  .map_reject   (map_reject),
  .commit_fire  (commit_fire),
  .is_commit    (is_commit),
  .pending      (pending),
  .shadow_mask  (shadow_mask)
);

// File: tb/xpc_cfg_ctrl_tb.sv
module xpc_cfg_ctrl_tb;
  localparam int N  = 8;
  localparam int PW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            msg_valid_i = 1'b0;
  logic            msg_kind_i = 1'b0;
  logic [N*PW-1:0] msg_map_i = '0;
  logic [N-1:0]    msg_mask_i = '0;
  logic            ack_o, ack_commit_o, fwd_o;
  logic [N*PW-1:0] active_map_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [PW-1:0] exp_act [N];
  logic [PW-1:0] stg_map [N];
  logic [N-1:0]  stg_mask;
  bit            stg_pend;

  always #2 clk = ~clk;

  xpc_cfg_ctrl #(.N_PORTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .msg_valid_i(msg_valid_i), .msg_kind_i(msg_kind_i),
    .msg_map_i(msg_map_i), .msg_mask_i(msg_mask_i), .ack_o(ack_o),
    .ack_commit_o(ack_commit_o), .fwd_o(fwd_o), .active_map_o(active_map_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*PW-1:0] pack(input logic [PW-1:0] m [N]);
    logic [N*PW-1:0] v;
    for (int i = 0; i < N; i++) v[i*PW +: PW] = m[i];
    return v;
  endfunction

  // consistency rule of the requirements, stated per port
  function automatic bit map_valid(input logic [PW-1:0] m [N], input logic [N-1:0] mk);
    for (int p = 0; p < N; p++) begin
      if (!mk[p]) continue;
      if (m[p] != PW'(p) && (!mk[m[p]] || m[m[p]] != PW'(p))) return 0;
      if (!mk[exp_act[p]]) return 0;
    end
    return 1;
  endfunction

  function automatic bit out_involution(input logic [N*PW-1:0] a);
    for (int p = 0; p < N; p++)
      if (a[a[p*PW +: PW]*PW +: PW] != PW'(p)) return 0;
    return 1;
  endfunction

  task automatic check_active(input string req);
    chk(req, {8'h0, active_map_o}, {8'h0, pack(exp_act)});
    chk("R7 involution", {31'h0, out_involution(active_map_o)}, 32'h1);
  endtask

  task automatic send(input bit kind, input logic [PW-1:0] m [N], input logic [N-1:0] mk,
                      input bit valid, input string req);
    bit e_ack, e_com;
    @(negedge clk);
    msg_valid_i = valid; msg_kind_i = kind; msg_map_i = pack(m); msg_mask_i = mk;
    e_ack = 0; e_com = 0;
    if (valid && kind == 1'b0) begin
      if (map_valid(m, mk)) begin
        e_ack = 1; stg_map = m; stg_mask = mk; stg_pend = 1;
      end
    end else if (valid && kind == 1'b1 && stg_pend) begin
      e_ack = 1; e_com = 1; stg_pend = 0;
      for (int p = 0; p < N; p++) if (stg_mask[p]) exp_act[p] = stg_map[p];
    end
    @(negedge clk);
    msg_valid_i = 1'b0;
    chk({req, " ack"}, {31'h0, ack_o}, {31'h0, e_ack});
    chk({req, " kind/fwd"}, {30'h0, ack_o && ack_commit_o, fwd_o}, {30'h0, e_com, e_com});
    check_active({req, " active"});
  endtask

  task automatic commit(input string req);
    logic [PW-1:0] z [N];
    for (int i = 0; i < N; i++) z[i] = '0;
    send(1'b1, z, '0, 1'b1, req);
  endtask

  function automatic void ident(output logic [PW-1:0] m [N]);
    for (int i = 0; i < N; i++) m[i] = PW'(i);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [PW-1:0] m [N];
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) exp_act[i] = PW'(i);
    stg_pend = 0; stg_mask = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ack", {30'h0, ack_o, fwd_o}, 32'h0);
    check_active("R1 identity");
    rst_n = 1'b1;
    @(negedge clk);

    commit("R6 commit with nothing staged");

    ident(m); m[0] = 1; m[1] = 0; m[2] = 3; m[3] = 2;
    send(1'b0, m, 8'h0F, 1'b1, "R2 map staged");
    commit("R4 commit applies");
    commit("R6 repeated commit");

    ident(m); m[4] = 5; m[5] = 4; m[0] = 7;
    send(1'b0, m, 8'h30, 1'b1, "R2 second map");
    commit("R5 unflagged ports hold");

    ident(m); m[6] = 7;
    send(1'b0, m, 8'hC0, 1'b1, "R3 asymmetric");
    send(1'b0, m, 8'h40, 1'b1, "R3 unflagged peer");
    ident(m);
    send(1'b0, m, 8'h01, 1'b1, "R3 active partner unflagged");
    commit("R3 nothing staged after rejects");

    ident(m); m[6] = 7; m[7] = 6;
    send(1'b0, m, 8'hC0, 1'b1, "R8 first map");
    ident(m);
    send(1'b0, m, 8'h03, 1'b1, "R8 replacing map");
    ident(m); m[1] = 5; m[5] = 1;
    send(1'b0, m, 8'h22, 1'b1, "R3 reject keeps staged");
    commit("R8 replacement applied");

    ident(m); m[6] = 7; m[7] = 6;
    send(1'b0, m, 8'hC0, 1'b0, "R9 map with valid low");
    commit("R9 nothing staged");

    for (int it = 0; it < 400; it++) begin
      int op;
      logic [N-1:0] mk;
      int lst [N];
      int cnt;
      op = $urandom % 10;
      if (op < 3) begin
        commit("R4 random commit");
      end else begin
        mk = N'($urandom);
        for (int p = 0; p < N; p++) if (mk[p]) mk[exp_act[p]] = 1'b1;
        ident(m);
        cnt = 0;
        for (int p = 0; p < N; p++) if (mk[p]) begin lst[cnt] = p; cnt++; end
        for (int k = cnt - 1; k > 0; k--) begin
          int j, t;
          j = $urandom % (k + 1);
          t = lst[k]; lst[k] = lst[j]; lst[j] = t;
        end
        for (int k = 0; k + 1 < cnt; k += 2) begin
          if ($urandom % 4 != 0) begin
            m[lst[k]] = PW'(lst[k+1]); m[lst[k+1]] = PW'(lst[k]);
          end
        end
        if (op >= 8 && cnt > 0) m[lst[0]] = PW'($urandom);
        send(1'b0, m, mk, ($urandom % 8) != 0, "R3 random map");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule